// File: doc/BRIEF.md
# Accumulator ALU with Flag Logic

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle it takes an operation code, two operands, and the carry and decimal flags the sequencer holds. One clock later it presents a result, a strobe that says whether the result is to be written back, and new values for the negative (N), overflow (V), zero (Z) and carry (C) flags. A four-bit mask names the flags that the operation updates. The sequencer keeps its stored flag where the mask bit is clear.

Operand A is the register the operation works on: the accumulator, an index register for compares, or a memory byte for increment and decrement. Operand B is the second source. Compare and bit test change only flags and never produce a result to write. Subtraction treats the carry as an inverted borrow. The decimal flag is carried through unchanged; no decimal correction is applied.

Top module: `acc_alu`

## Requirements
- R1: While the synchronous active-high reset is sampled high, every output is driven to zero on the next clock edge.
- R2: Every output is registered. Inputs sampled at a clock edge appear on the outputs just after that edge. The operation codes are: 0 none, 1 add, 2 subtract, 3 compare, 4 bit test, 5 AND, 6 OR, 7 XOR, 8 shift left, 9 logical shift right, 10 rotate left, 11 rotate right, 12 increment, 13 decrement. Codes 14 and 15 behave as code 0.
- R3: Add gives {C, result} = A + B + carry_in. V is set when A and B have the same sign and the result's sign differs from it. All four flags are updated and the result is written.
- R4: Subtract gives result = A - B - (1 - carry_in). C is set when no borrow occurs. V is set when A and B have different signs and the result's sign differs from A's. All four flags are updated and the result is written.
- R5: Compare forms A - B. N and Z come from the difference, and C is set when A is unsigned greater than or equal to B. The mask covers N, Z and C only, and nothing is written.
- R6: Bit test copies B bit 7 into N and B bit 6 into V. Z is set when A AND B is zero. The mask covers N, V and Z, and nothing is written.
- R7: AND, OR and XOR combine A and B bitwise. Only N and Z are updated. XOR with 0xFF gives the complement of A.
- R8: Shift left fills bit 0 with zero. Logical shift right fills bit 7 with zero. In both, the bit shifted out goes to C, and N, Z and C are updated.
- R9: Rotate left moves carry_in into bit 0 and bit 7 into C. Rotate right moves carry_in into bit 7 and bit 0 into C. N, Z and C are updated.
- R10: Increment and decrement return A + 1 and A - 1 modulo 256. Only N and Z are updated.
- R11: The mask bits are flag_upd_o[3]=N, [2]=V, [1]=Z, [0]=C. A flag output whose mask bit is clear reads 0. The result reads 0 while the write strobe is low. Codes 0, 14 and 15 give no write and an empty mask.
- R12: dec_o repeats dec_i one cycle later, and dec_i has no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Operand A (target register or memory byte) |
| b_i | input | 8 | Operand B |
| carry_i | input | 1 | Incoming carry flag |
| dec_i | input | 1 | Incoming decimal flag |
| res_o | output | 8 | Result |
| wr_en_o | output | 1 | Result write strobe |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| flag_upd_o | output | 4 | Flag update mask {N,V,Z,C} |
| dec_o | output | 1 | Decimal flag, passed through |

## Verification
The assertions check, on every cycle, properties that hold for any operand: the 9-bit sum of an add, the missing write and unsigned carry of a compare, the bits that bit test copies, the rule that masked-off flags and unwritten results read zero, and the pass-through of the decimal flag. Only the bench's scenarios can show signed overflow at chosen sign boundaries, subtraction with and without borrow, carry fill on the rotates, and wrap-around on increment and decrement. The same holds for the logic operations, whose flag values come from specific operand patterns.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_BIT  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11,
    OP_INC  = 4'd12,
    OP_DEC  = 4'd13
  } alu_op_e;

  // mask layout {N,V,Z,C}
  localparam logic [3:0] MASK_NVZC = 4'b1111;
  localparam logic [3:0] MASK_NZC  = 4'b1011;
  localparam logic [3:0] MASK_NVZ  = 4'b1110;
  localparam logic [3:0] MASK_NZ   = 4'b1010;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  always_comb begin
    b_eff = sub ? ~b : b;
    total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = total[W-1:0];
    cout  = total[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (total[W-1] != a[W-1]);
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SHL: begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
      OP_SHR: begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
      OP_ROL: begin res = {a[W-2:0], cin};  cout = a[W-1]; end
      OP_ROR: begin res = {cin, a[W-1:1]};  cout = a[0];   end
      OP_INC: res = a + {{(W-1){1'b0}}, 1'b1};
      OP_DEC: res = a - {{(W-1){1'b0}}, 1'b1};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         dec_i,
  output logic [W-1:0] res_o,
  output logic         wr_en_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o,
  output logic [3:0]   flag_upd_o,
  output logic         dec_o
);
  localparam int MSB = W - 1;
  localparam int SUB_MSB = W - 2;

  alu_op_e      op;
  logic         as_sub, as_cin;
  logic [W-1:0] as_sum, bo_res;
  logic         as_cout, as_ovf, bo_cout;

  logic [W-1:0] nx_res, nz_src;
  logic         nx_wr, nx_n, nx_v, nx_z, nx_c;
  logic [3:0]   nx_mask;

  assign op     = alu_op_e'(op_i);
  assign as_sub = (op == OP_SUB) || (op == OP_CMP);
  assign as_cin = (op == OP_CMP) ? 1'b1 : carry_i;

  acc_alu_addsub #(.W(W)) u_addsub (
    .a(a_i), .b(b_i), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  acc_alu_bitops #(.W(W)) u_bitops (
    .op(op), .a(a_i), .b(b_i), .cin(carry_i),
    .res(bo_res), .cout(bo_cout)
  );

  always_comb begin
    nz_src  = bo_res;
    nx_wr   = 1'b0;
    nx_v    = 1'b0;
    nx_c    = bo_cout;
    nx_mask = 4'b0000;
    nx_n    = 1'b0;
    nx_z    = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        nz_src = as_sum; nx_c = as_cout; nx_v = as_ovf;
        nx_mask = MASK_NVZC; nx_wr = 1'b1;
      end
      OP_CMP: begin
        nz_src = as_sum; nx_c = as_cout; nx_mask = MASK_NZC;
      end
      OP_BIT: begin
        nz_src = a_i & b_i; nx_mask = MASK_NVZ;
        nx_v = b_i[SUB_MSB];
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        nx_mask = MASK_NZ; nx_wr = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        nx_mask = MASK_NZC; nx_wr = 1'b1;
      end
      default: nx_mask = 4'b0000;
    endcase
    nx_n   = (op == OP_BIT) ? b_i[MSB] : nz_src[MSB];
    nx_z   = (nz_src == '0);
    nx_res = nx_wr ? nz_src : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o      <= '0;
      wr_en_o    <= 1'b0;
      n_o        <= 1'b0;
      v_o        <= 1'b0;
      z_o        <= 1'b0;
      c_o        <= 1'b0;
      flag_upd_o <= 4'b0000;
      dec_o      <= 1'b0;
    end else begin
      res_o      <= nx_res;
      wr_en_o    <= nx_wr;
      n_o        <= nx_n & nx_mask[3];
      v_o        <= nx_v & nx_mask[2];
      z_o        <= nx_z & nx_mask[1];
      c_o        <= nx_c & nx_mask[0];
      flag_upd_o <= nx_mask;
      dec_o      <= dec_i;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         carry_i,
  input logic         dec_i,
  input logic [W-1:0] res_o,
  input logic         wr_en_o,
  input logic         n_o,
  input logic         v_o,
  input logic         z_o,
  input logic         c_o,
  input logic [3:0]   flag_upd_o,
  input logic         dec_o
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_i) == 4'(OP_ADD) |->
      {c_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{W{1'b0}}, $past(carry_i)}));

  p_cmp_flags_r5: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_i) == 4'(OP_CMP) |->
      !wr_en_o && !flag_upd_o[2] && (c_o == ($past(a_i) >= $past(b_i))));

  p_bit_copy_r6: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(op_i) == 4'(OP_BIT) |->
      !wr_en_o && n_o == $past(b_i[W-1]) && v_o == $past(b_i[W-2])
      && z_o == (($past(a_i) & $past(b_i)) == '0));

  p_masked_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (({n_o, v_o, z_o, c_o} & ~flag_upd_o) == 4'b0000));

  p_nowrite_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |-> res_o == '0);

  p_dec_pass_r12: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> dec_o == $past(dec_i));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .carry_i(carry_i), .dec_i(dec_i), .res_o(res_o), .wr_en_o(wr_en_o),
  .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
  .flag_upd_o(flag_upd_o), .dec_o(dec_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = 4'd0;
  logic [7:0] a_i = 8'd0, b_i = 8'd0;
  logic       carry_i = 1'b0, dec_i = 1'b0;
  logic [7:0] res_o;
  logic       wr_en_o, n_o, v_o, z_o, c_o, dec_o;
  logic [3:0] flag_upd_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .carry_i(carry_i), .dec_i(dec_i), .res_o(res_o), .wr_en_o(wr_en_o),
    .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
    .flag_upd_o(flag_upd_o), .dec_o(dec_o)
  );

  // expected outputs packed {res, wr, mask, N, V, Z, C, dec}
  function automatic logic [17:0] expect_of(input logic [3:0] op, input logic [7:0] a,
                                             input logic [7:0] b, input logic c, input logic d);
    int t;
    logic [7:0] r;
    logic wr, nn, vv, zz, cc;
    logic [3:0] m;
    r = 8'd0; wr = 1'b0; nn = 1'b0; vv = 1'b0; cc = 1'b0; m = 4'b0000;
    case (op)
      4'd1: begin t = int'(a) + int'(b) + int'(c); r = t[7:0]; cc = (t > 255);
              vv = (a[7] == b[7]) && (r[7] != a[7]); m = 4'b1111; wr = 1; end
      4'd2: begin t = int'(a) - int'(b) - (1 - int'(c)); r = t[7:0]; cc = (t >= 0);
              vv = (a[7] != b[7]) && (r[7] != a[7]); m = 4'b1111; wr = 1; end
      4'd3: begin r = a - b; cc = (a >= b); m = 4'b1011; end
      4'd4: begin r = a & b; m = 4'b1110; vv = b[6]; end
      4'd5: begin r = a & b; m = 4'b1010; wr = 1; end
      4'd6: begin r = a | b; m = 4'b1010; wr = 1; end
      4'd7: begin r = a ^ b; m = 4'b1010; wr = 1; end
      4'd8: begin r = a << 1; cc = a[7]; m = 4'b1011; wr = 1; end
      4'd9: begin r = a >> 1; cc = a[0]; m = 4'b1011; wr = 1; end
      4'd10: begin r = {a[6:0], c}; cc = a[7]; m = 4'b1011; wr = 1; end
      4'd11: begin r = {c, a[7:1]}; cc = a[0]; m = 4'b1011; wr = 1; end
      4'd12: begin r = a + 8'd1; m = 4'b1010; wr = 1; end
      4'd13: begin r = a - 8'd1; m = 4'b1010; wr = 1; end
      default: begin r = 8'd0; end
    endcase
    nn = (op == 4'd4) ? b[7] : r[7];
    zz = (r == 8'd0);
    if (!wr) r = 8'd0;
    return {r, wr, m, nn & m[3], vv & m[2], zz & m[1], cc & m[0], d};
  endfunction

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got res=%h wr=%b mask=%b nvzc=%b dec=%b, expected res=%h wr=%b mask=%b nvzc=%b dec=%b",
               req, got[17:10], got[9], got[8:5], got[4:1], got[0],
               exp[17:10], exp[9], exp[8:5], exp[4:1], exp[0]);
    end
  endtask

  function automatic logic [17:0] outs();
    return {res_o, wr_en_o, flag_upd_o, n_o, v_o, z_o, c_o, dec_o};
  endfunction

  // drive at falling edge, result registered on next rising edge, sample at following falling edge
  task automatic apply(input string req, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c, input logic d);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; carry_i = c; dec_i = d;
    @(negedge clk);
    check(req, outs(), expect_of(op, a, b, c, d));
  endtask

  task automatic t_reset();
    @(negedge clk);
    op_i = 4'd1; a_i = 8'hFF; b_i = 8'hFF; carry_i = 1; dec_i = 1; rst = 1;
    @(negedge clk);
    check("R1", outs(), 18'd0);
    rst = 0;
  endtask

  task automatic t_latency();
    // R2: output holds old value until the edge after the input changes
    apply("R2", 4'd5, 8'hF0, 8'h3C, 0, 0);
    op_i = 4'd6; a_i = 8'h01; b_i = 8'h02;
    #2;
    check("R2", outs(), expect_of(4'd5, 8'hF0, 8'h3C, 0, 0));
    @(negedge clk);
    check("R2", outs(), expect_of(4'd6, 8'h01, 8'h02, 0, 0));
  endtask

  task automatic t_add();
    apply("R3", 4'd1, 8'h50, 8'h50, 0, 0);
    apply("R3", 4'd1, 8'hFF, 8'h01, 0, 0);
    apply("R3", 4'd1, 8'h12, 8'h34, 1, 0);
    apply("R3", 4'd1, 8'h80, 8'h80, 1, 0);
  endtask

  task automatic t_sub();
    apply("R4", 4'd2, 8'h00, 8'h01, 1, 0);
    apply("R4", 4'd2, 8'h80, 8'h01, 1, 0);
    apply("R4", 4'd2, 8'h10, 8'h05, 0, 0);
    apply("R4", 4'd2, 8'h7F, 8'hFF, 1, 0);
  endtask

  task automatic t_cmp();
    apply("R5", 4'd3, 8'h40, 8'h40, 0, 0);
    apply("R5", 4'd3, 8'h10, 8'h20, 1, 0);
    apply("R5", 4'd3, 8'hF0, 8'h01, 0, 0);
    apply("R5", 4'd3, 8'h80, 8'h01, 0, 0);
  endtask

  task automatic t_bit();
    apply("R6", 4'd4, 8'h0F, 8'hC0, 0, 0);
    apply("R6", 4'd4, 8'h41, 8'h41, 1, 0);
    apply("R6", 4'd4, 8'hFF, 8'h80, 0, 0);
  endtask

  task automatic t_logic();
    apply("R7", 4'd5, 8'hAA, 8'h55, 0, 0);
    apply("R7", 4'd6, 8'h80, 8'h01, 0, 0);
    apply("R7", 4'd7, 8'h5A, 8'hFF, 1, 0);
    apply("R7", 4'd7, 8'h3C, 8'h3C, 0, 0);
  endtask

  task automatic t_shift();
    apply("R8", 4'd8, 8'h81, 8'h00, 1, 0);
    apply("R8", 4'd8, 8'h40, 8'h00, 0, 0);
    apply("R8", 4'd9, 8'h01, 8'h00, 1, 0);
    apply("R8", 4'd9, 8'hFE, 8'h00, 0, 0);
  endtask

  task automatic t_rotate();
    apply("R9", 4'd10, 8'h80, 8'h00, 0, 0);
    apply("R9", 4'd10, 8'h40, 8'h00, 1, 0);
    apply("R9", 4'd11, 8'h01, 8'h00, 0, 0);
    apply("R9", 4'd11, 8'h02, 8'h00, 1, 0);
  endtask

  task automatic t_incdec();
    apply("R10", 4'd12, 8'hFF, 8'h00, 1, 0);
    apply("R10", 4'd12, 8'h7F, 8'h00, 0, 0);
    apply("R10", 4'd13, 8'h00, 8'h00, 0, 0);
    apply("R10", 4'd13, 8'h01, 8'h00, 1, 0);
  endtask

  task automatic t_none();
    apply("R11", 4'd0, 8'h12, 8'h34, 1, 0);
    apply("R11", 4'd14, 8'hFF, 8'hFF, 1, 0);
    apply("R11", 4'd15, 8'h00, 8'h00, 0, 0);
  endtask

  task automatic t_decimal();
    apply("R12", 4'd1, 8'h09, 8'h01, 0, 1);
    apply("R12", 4'd2, 8'h10, 8'h01, 1, 1);
    apply("R12", 4'd0, 8'h00, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_cmp();
    t_bit();
    t_logic();
    t_shift();
    t_rotate();
    t_incdec();
    t_none();
    t_decimal();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule